// File: doc/BRIEF.md
# Latched Status Register Bank with Masked Clear

The block holds three byte-wide event registers that a host reads over a simple parallel bus: alarm register A, alarm register B and a receive information register. A bit in any of them latches to 1 when its event input is high in a clock cycle. It then stays at 1 until the host clears it. Event producers such as the framer, the zero detectors and the elastic store sit outside the block and reach it as per-bit pulse inputs. A separate loss-of-sync level input feeds bit 0 of alarm register A.

An access to a status register has two steps. First the host writes a mask byte to it. For every 1 in the mask, the latched bit is copied into a host-visible read copy and the latched bit is cleared. For every 0 in the mask, both the latched bit and its read copy stay as they were. The host then reads the read copy, and a read has no side effects. To be certain a bit is cleared, software writes (read value AND mask) back to the same register. That second write also catches any event that arrived between the first write and the read.

Alarm registers A and B each drive a registered, active-low interrupt output through their own mask register. The receive information register never raises an interrupt.

Top module: `stat_latch_bank`

## Requirements
- R1: After reset every latched bit, read copy and interrupt mask is 0, a read of any of the five registers returns 0x00, and both `irq_a_no` and `irq_b_no` are 1.
- R2: An event input that is high for one cycle sets its latched bit. The bit stays at 1 through any number of idle cycles and reads until a mask write clears it.
- R3: A write to a status register loads the read copy with the current latched value in every bit where the write data is 1, and clears those latched bits. A later write of the same mask reads back 0 when no new event has occurred.
- R4: In every bit where the write data is 0, the read copy keeps its previous value and the latched bit is not changed.
- R5: While `los_i` is 1, bit 0 of alarm register A sets again in the very cycle it is cleared, so every mask write of 0x01 captures 1. After `los_i` falls, the bit stays latched until one more clear, and only then reads 0.
- R6: An event that arrives after a mask write and before the write-back of (read AND mask) is captured by that write-back and cleared by it.
- R7: `irq_a_no` is 0 one cycle after any bit of alarm register A is 1 while the same bit of mask register A is 1, and 1 otherwise. `irq_b_no` follows alarm register B and mask register B in the same way. Unmasked events do not pull the output low.
- R8: Events in the receive information register never pull either interrupt output low, even with both masks at 0xFF. The register's bit layout from bit 7 down to bit 0 is: frame alignment change, 8-zero detect, 16-zero detect, elastic store full, elastic store empty, severely errored frame, B8ZS code seen, frame bit error.
- R9: When an event sets a bit in the same cycle that a mask write clears it, the bit stays latched. The read copy gets the pre-event value, and the next mask write captures 1.
- R10: A read returns the addressed register on `rdata_o` one clock edge after `rd_i`. Reads never clear or change any latched bit or read copy.
- R11: The addresses are: alarm A 0x20, alarm B 0x21, receive information 0x22, mask A 0x18, mask B 0x19. Mask registers read back the value written to them. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data / clear mask |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Registered read data |
| alm_a_evt_i | input | 8 | Event pulses for alarm register A |
| los_i | input | 1 | Loss-of-sync level, sets alarm A bit 0 |
| alm_b_evt_i | input | 8 | Event pulses for alarm register B |
| rx_evt_i | input | 8 | Event pulses for receive information register |
| irq_a_no | output | 1 | Interrupt from alarm A, active low |
| irq_b_no | output | 1 | Interrupt from alarm B, active low |

## Verification
The set path and the masked-clear path can hit the same bit in the same clock. This happens when an event pulse coincides with a host mask write, or when the loss-of-sync level is still high while its bit is being cleared. The bench provokes both cases. It drives an event and a mask write to the same bit in one cycle. It also holds `los_i` high across repeated clears. In each case the bench judges the result from the following reads. The first read copy must show the pre-event value, and the next mask write must still capture a 1. That 1 must then clear away once the condition is gone.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;
  localparam int unsigned NUM_STAT = 3;
  localparam int unsigned NUM_WE = 5;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_ALM_A  = 3'd1,
    SEL_ALM_B  = 3'd2,
    SEL_RX     = 3'd3,
    SEL_MASK_A = 3'd4,
    SEL_MASK_B = 3'd5
  } reg_sel_e;

  // write-enable vector positions
  localparam int unsigned WE_ALM_A  = 0;
  localparam int unsigned WE_ALM_B  = 1;
  localparam int unsigned WE_RX     = 2;
  localparam int unsigned WE_MASK_A = 3;
  localparam int unsigned WE_MASK_B = 4;
endpackage

// File: rtl/stat_addr_dec.sv
module stat_addr_dec
  import stat_pkg::*;
#(
  parameter int unsigned   AW         = 8,
  parameter logic [AW-1:0] ADDR_ALM_A  = 8'h20,
  parameter logic [AW-1:0] ADDR_ALM_B  = 8'h21,
  parameter logic [AW-1:0] ADDR_RX     = 8'h22,
  parameter logic [AW-1:0] ADDR_MASK_A = 8'h18,
  parameter logic [AW-1:0] ADDR_MASK_B = 8'h19
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  output reg_sel_e          sel_o,
  output logic [NUM_WE-1:0] we_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_ALM_A:  sel_o = SEL_ALM_A;
      ADDR_ALM_B:  sel_o = SEL_ALM_B;
      ADDR_RX:     sel_o = SEL_RX;
      ADDR_MASK_A: sel_o = SEL_MASK_A;
      ADDR_MASK_B: sel_o = SEL_MASK_B;
      default:     sel_o = SEL_NONE;
    endcase
  end

  always_comb begin
    we_o = '0;
    if (wr_i) begin
      unique case (sel_o)
        SEL_ALM_A:  we_o[WE_ALM_A]  = 1'b1;
        SEL_ALM_B:  we_o[WE_ALM_B]  = 1'b1;
        SEL_RX:     we_o[WE_RX]     = 1'b1;
        SEL_MASK_A: we_o[WE_MASK_A] = 1'b1;
        SEL_MASK_B: we_o[WE_MASK_B] = 1'b1;
        default:    we_o = '0;
      endcase
    end
  end

  // R11: at most one target per write
  always_comb begin
    a_one_target_r11: assert ($onehot0(we_o));
  end
endmodule

// File: rtl/stat_sticky_reg.sv
module stat_sticky_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wmask_i,
  output logic [DW-1:0] latch_o,
  output logic [DW-1:0] copy_o
);
  logic [DW-1:0] latch_q, copy_q, clr;

  assign clr = wr_en_i ? wmask_i : '0;

  // set has priority over clear per bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= (latch_q & ~clr) | set_i;
  end

  for (genvar b = 0; b < DW; b++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     copy_q[b] <= 1'b0;
      else if (clr[b]) copy_q[b] <= latch_q[b];
    end
  end

  assign latch_o = latch_q;
  assign copy_o  = copy_q;

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_q != '0) |=> (($past(latch_q) & ~$past(clr) & ~latch_q) == '0)));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i |=> ((latch_q & $past(clr) & ~$past(set_i)) == '0)));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i |=> (((copy_q ^ $past(copy_q)) & ~$past(wmask_i)) == '0)));
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i != '0) |=> (($past(set_i) & ~latch_q) == '0)));
endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] latch_i,
  output logic [DW-1:0] mask_o,
  output logic          irq_no
);
  logic [DW-1:0] mask_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b1;
    else         irq_q <= ~|(latch_i & mask_q);
  end

  assign mask_o = mask_q;
  assign irq_no = irq_q;

  p_irq_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_i & mask_q) != '0) |=> !irq_no);
  p_irq_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_i & mask_q) == '0) |=> irq_no);
endmodule

// File: rtl/stat_latch_bank.sv
module stat_latch_bank
  import stat_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 8,
  parameter int unsigned LOS_BIT = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] alm_a_evt_i,
  input  logic          los_i,
  input  logic [DW-1:0] alm_b_evt_i,
  input  logic [DW-1:0] rx_evt_i,
  output logic          irq_a_no,
  output logic          irq_b_no
);
  localparam int unsigned IDX_A  = 0;
  localparam int unsigned IDX_B  = 1;
  localparam int unsigned IDX_RX = 2;

  reg_sel_e          sel;
  logic [NUM_WE-1:0] we;
  logic [DW-1:0]     set_v   [NUM_STAT];
  logic [DW-1:0]     latch_v [NUM_STAT];
  logic [DW-1:0]     copy_v  [NUM_STAT];
  logic [NUM_STAT-1:0] stat_we;
  logic [DW-1:0]     los_vec, mask_a, mask_b, rd_mux, rdata_q;

  stat_addr_dec #(.AW(AW)) i_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .sel_o  (sel),
    .we_o   (we)
  );

  // level alarm: sets every cycle it is present
  assign los_vec          = DW'(los_i) << LOS_BIT;
  assign set_v[IDX_A]     = alm_a_evt_i | los_vec;
  assign set_v[IDX_B]     = alm_b_evt_i;
  assign set_v[IDX_RX]    = rx_evt_i;
  assign stat_we[IDX_A]   = we[WE_ALM_A];
  assign stat_we[IDX_B]   = we[WE_ALM_B];
  assign stat_we[IDX_RX]  = we[WE_RX];

  for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
    stat_sticky_reg #(.DW(DW)) i_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_v[k]),
      .wr_en_i (stat_we[k]),
      .wmask_i (wdata_i),
      .latch_o (latch_v[k]),
      .copy_o  (copy_v[k])
    );
  end

  stat_irq_gen #(.DW(DW)) i_irq_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (we[WE_MASK_A]),
    .wdata_i (wdata_i),
    .latch_i (latch_v[IDX_A]),
    .mask_o  (mask_a),
    .irq_no  (irq_a_no)
  );

  stat_irq_gen #(.DW(DW)) i_irq_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (we[WE_MASK_B]),
    .wdata_i (wdata_i),
    .latch_i (latch_v[IDX_B]),
    .mask_o  (mask_b),
    .irq_no  (irq_b_no)
  );

  always_comb begin
    unique case (sel)
      SEL_ALM_A:  rd_mux = copy_v[IDX_A];
      SEL_ALM_B:  rd_mux = copy_v[IDX_B];
      SEL_RX:     rd_mux = copy_v[IDX_RX];
      SEL_MASK_A: rd_mux = mask_a;
      SEL_MASK_B: rd_mux = mask_b;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  p_read_pure_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && set_v[IDX_A] == '0 && set_v[IDX_B] == '0 && set_v[IDX_RX] == '0)
      |=> ($stable(latch_v[IDX_A]) && $stable(latch_v[IDX_B]) && $stable(latch_v[IDX_RX])
           && $stable(copy_v[IDX_A]) && $stable(copy_v[IDX_RX])));
endmodule

// File: tb/test_stat_latch_bank.sv
module test_stat_latch_bank;
  localparam logic [7:0] A_ALM_A = 8'h20, A_ALM_B = 8'h21, A_RX = 8'h22;
  localparam logic [7:0] A_MSK_A = 8'h18, A_MSK_B = 8'h19;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0, rdata_o;
  logic       wr_i = 1'b0, rd_i = 1'b0, los_i = 1'b0;
  logic [7:0] alm_a_evt_i = '0, alm_b_evt_i = '0, rx_evt_i = '0;
  logic       irq_a_no, irq_b_no;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #10 clk_i = ~clk_i;

  stat_latch_bank i_stat_latch_bank (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rd_i, .rdata_o,
    .alm_a_evt_i, .los_i, .alm_b_evt_i, .rx_evt_i, .irq_a_no, .irq_b_no
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    check(req, rdata_o, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(int which, logic [7:0] v);
    @(negedge clk_i);
    case (which)
      0: alm_a_evt_i = v;
      1: alm_b_evt_i = v;
      default: rx_evt_i = v;
    endcase
    @(negedge clk_i);
    alm_a_evt_i = '0; alm_b_evt_i = '0; rx_evt_i = '0;
  endtask

  task automatic clean(logic [7:0] a);
    wr(a, 8'hFF); wr(a, 8'hFF);
  endtask

  task automatic t_reset();
    rd_chk("R1 alm_a", A_ALM_A, 8'h00);
    rd_chk("R1 alm_b", A_ALM_B, 8'h00);
    rd_chk("R1 rx", A_RX, 8'h00);
    rd_chk("R1 mask_a", A_MSK_A, 8'h00);
    rd_chk("R1 mask_b", A_MSK_B, 8'h00);
    check("R1 irq_a", {7'd0, irq_a_no}, 8'h01);
    check("R1 irq_b", {7'd0, irq_b_no}, 8'h01);
  endtask

  task automatic t_sticky();
    clean(A_ALM_A);
    pulse(0, 8'h08); idle(3);
    wr(A_ALM_A, 8'h08); rd_chk("R2 held bit", A_ALM_A, 8'h08);
    wr(A_ALM_A, 8'h08); rd_chk("R3 cleared", A_ALM_A, 8'h00);
  endtask

  task automatic t_partial();
    clean(A_ALM_B);
    pulse(1, 8'h81);
    wr(A_ALM_B, 8'h01); rd_chk("R3 selected bit only", A_ALM_B, 8'h01);
    wr(A_ALM_B, 8'h80); rd_chk("R4 unselected copy held", A_ALM_B, 8'h81);
    wr(A_ALM_B, 8'hFF); rd_chk("R3 both cleared", A_ALM_B, 8'h00);
  endtask

  task automatic t_los();
    clean(A_ALM_A);
    @(negedge clk_i); los_i = 1'b1; idle(2);
    wr(A_ALM_A, 8'h01); rd_chk("R5 los first", A_ALM_A, 8'h01);
    wr(A_ALM_A, 8'h01); rd_chk("R5 los relatched", A_ALM_A, 8'h01);
    @(negedge clk_i); los_i = 1'b0; idle(1);
    wr(A_ALM_A, 8'h01); rd_chk("R5 los still latched", A_ALM_A, 8'h01);
    wr(A_ALM_A, 8'h01); rd_chk("R5 los gone", A_ALM_A, 8'h00);
  endtask

  task automatic t_write_back();
    clean(A_RX);
    pulse(2, 8'h20);
    wr(A_RX, 8'h30); rd_chk("R6 first capture", A_RX, 8'h20);
    pulse(2, 8'h20);
    wr(A_RX, 8'h20 & 8'h30); rd_chk("R6 write-back captures", A_RX, 8'h20);
    wr(A_RX, 8'h20); rd_chk("R6 write-back cleared", A_RX, 8'h00);
  endtask

  task automatic t_irq();
    clean(A_ALM_A); clean(A_ALM_B);
    wr(A_MSK_A, 8'h04);
    pulse(0, 8'h02); idle(2);
    check("R7 masked event no irq", {7'd0, irq_a_no}, 8'h01);
    pulse(0, 8'h04); idle(2);
    check("R7 unmasked event irq_a", {7'd0, irq_a_no}, 8'h00);
    wr(A_ALM_A, 8'h04); idle(2);
    check("R7 irq_a released", {7'd0, irq_a_no}, 8'h01);
    clean(A_ALM_A);
    wr(A_MSK_B, 8'h80);
    pulse(1, 8'h80); idle(2);
    check("R7 irq_b asserted", {7'd0, irq_b_no}, 8'h00);
    check("R7 irq_a unaffected", {7'd0, irq_a_no}, 8'h01);
    wr(A_ALM_B, 8'h80); idle(2);
    check("R7 irq_b released", {7'd0, irq_b_no}, 8'h01);
    wr(A_MSK_A, 8'h00); wr(A_MSK_B, 8'h00);
  endtask

  task automatic t_rx_noirq();
    wr(A_MSK_A, 8'hFF); wr(A_MSK_B, 8'hFF);
    clean(A_RX);
    pulse(2, 8'hFF); idle(2);
    check("R8 irq_a quiet", {7'd0, irq_a_no}, 8'h01);
    check("R8 irq_b quiet", {7'd0, irq_b_no}, 8'h01);
    wr(A_RX, 8'h40); rd_chk("R8 eight-zero bit 6", A_RX, 8'h40);
    clean(A_RX);
    wr(A_MSK_A, 8'h00); wr(A_MSK_B, 8'h00);
  endtask

  task automatic t_set_wins();
    clean(A_ALM_B);
    @(negedge clk_i);
    alm_b_evt_i = 8'h10; addr_i = A_ALM_B; wdata_i = 8'h10; wr_i = 1'b1;
    @(negedge clk_i);
    alm_b_evt_i = '0; wr_i = 1'b0;
    rd_chk("R9 copy pre-event", A_ALM_B, 8'h00);
    wr(A_ALM_B, 8'h10); rd_chk("R9 event survived", A_ALM_B, 8'h10);
    wr(A_ALM_B, 8'h10); rd_chk("R9 then cleared", A_ALM_B, 8'h00);
  endtask

  task automatic t_read_pure();
    clean(A_ALM_A);
    pulse(0, 8'h40);
    for (int i = 0; i < 3; i++) rd_chk("R10 read stale copy", A_ALM_A, 8'h00);
    wr(A_ALM_A, 8'h40); rd_chk("R10 reads did not clear", A_ALM_A, 8'h40);
    rd_chk("R10 repeat read", A_ALM_A, 8'h40);
    wr(A_ALM_A, 8'h00); rd_chk("R4 zero mask holds copy", A_ALM_A, 8'h40);
    wr(A_ALM_A, 8'h40); rd_chk("R3 cleared after reads", A_ALM_A, 8'h00);
  endtask

  task automatic t_addr();
    wr(A_MSK_A, 8'h5A); wr(A_MSK_B, 8'hA5);
    rd_chk("R11 mask_a readback", A_MSK_A, 8'h5A);
    rd_chk("R11 mask_b readback", A_MSK_B, 8'hA5);
    wr(8'h23, 8'hFF); wr(8'h00, 8'h00);
    rd_chk("R11 mask_a untouched", A_MSK_A, 8'h5A);
    rd_chk("R11 mask_b untouched", A_MSK_B, 8'hA5);
    rd_chk("R11 unmapped reads zero", 8'h23, 8'h00);
    check("R11 irq_a idle", {7'd0, irq_a_no}, 8'h01);
    wr(A_MSK_A, 8'h00); wr(A_MSK_B, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk_i); rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_sticky();
    t_partial();
    t_los();
    t_write_back();
    t_irq();
    t_rx_noirq();
    t_set_wins();
    t_read_pure();
    t_addr();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule